// File: doc/BRIEF.md
# Complement-Pair Memory Pattern Tester

This block runs a short self-contained integrity check on a pair of adjacent 32-bit memory words. A one-cycle `start` pulse latches a test address formed from an 8-bit seed. The block then runs five rounds. In each round it writes a pattern to the first word and the bitwise inverse of that pattern to the word four bytes above it. It then reads the first word and the second word back and compares each against what it wrote.

Three of the patterns are fixed constants. The fourth packs three 8-bit tuning fields taken from the block's inputs. The fifth is a snapshot of a free-running cycle counter. Because the tuning word and a changing counter value are written as data, a test for each delay setting stores different bits at the same spot.

The first read that differs ends the run as a failure. A pass is reported only after all ten reads have matched. The memory side is a plain request/acknowledge port with one request outstanding at a time.

Top module: `cpair_mem_tester`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `pass` and `mem_req` are all 0.
- R2: The test address A is `BASE_ADDR + (seed + 255) * 4`. The seed is sampled on the clock edge that accepts `start`. All first-word accesses use A and all second-word accesses use A + 4.
- R3: Each round issues exactly four requests in this order: write P to A, write ~P to A + 4, read A, read A + 4. A request stays up until `mem_ack` is seen, and the next request begins in the following cycle.
- R4: The patterns of rounds one to four are, in order, 0x00000000, 0xAAAAAAAA, 0x12345678 and `(tune_hi << 16) | (tune_mid << 8) | tune_lo`.
- R5: The round-five pattern is the value of an internal counter that is cleared by reset and advances by one on every clock edge. The value taken is the counter's value just before the edge that begins round five, so it is one less than the number of edges since reset was released as seen during the first round-five write. The same value is written and compared in both halves of that round.
- R6: After the tenth read matches, `done` is 1 with `pass` = 1 in the next cycle, after exactly 20 requests, and no further request follows.
- R7: The first read whose data differs from what was written ends the run. In the next cycle `done` is 1 with `pass` = 0, and no further request is issued.
- R8: A `start` pulse that arrives while a run is in progress is ignored. The address and the request sequence of the current run are unchanged.
- R9: `done` is high for exactly one cycle per run. `pass` keeps its value until the next accepted `start`, which clears it.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_we`, `mem_addr` and `mem_wdata` are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| seed | input | SEED_W | Selects the test address |
| tune_hi | input | FIELD_W | Upper field of the fourth pattern |
| tune_mid | input | FIELD_W | Middle field of the fourth pattern |
| tune_lo | input | FIELD_W | Lower field of the fourth pattern |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Completes the pending request; read data is valid with it |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run, meaningful with `done` |

## Verification
A wrong state or round index in the sequencer shows up at the memory port on the very next request: the write/read flag, the address offset or the pattern is out of order. A mis-latched pattern appears as wrong write data in the first write of the affected round. A broken comparison shows up one cycle after the faulty read's acknowledge, as a `done` pulse with the wrong `pass` or a request that should not have been issued. An error in the snapshot timing shifts the round-five data by whole counts, which the bench detects against its own count of edges since reset.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    // Sequencer states; one per request kind plus idle
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WR_LO = 3'd1,
        ST_WR_HI = 3'd2,
        ST_RD_LO = 3'd3,
        ST_RD_HI = 3'd4
    } cpt_state_e;

    localparam int unsigned CPT_ROUNDS = 5;
    localparam int unsigned CPT_RND_W  = $clog2(CPT_ROUNDS + 1);

endpackage

// File: rtl/cpt_cycle_ctr.sv
module cpt_cycle_ctr #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R5: the counter never skips or stalls
    a_r5_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/cpt_addr_gen.sv
module cpt_addr_gen #(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          SEED_W    = 8,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 'hA000_0000
) (
    input  logic [SEED_W-1:0] seed,
    output logic [ADDR_W-1:0] test_addr
);

    localparam int unsigned        SUM_W = SEED_W + 1;
    localparam logic [SUM_W-1:0]   BIAS  = SUM_W'((1 << SEED_W) - 1);

    logic [SUM_W-1:0] biased;

    always_comb begin
        biased    = {1'b0, seed} + BIAS;
        test_addr = BASE_ADDR + (ADDR_W'(biased) << 2);
    end

endmodule

// File: rtl/cpt_pattern_sel.sv
module cpt_pattern_sel
    import cpt_pkg::*;
#(
    parameter int unsigned          DATA_W  = 32,
    parameter int unsigned          FIELD_W = 8,
    parameter logic [DATA_W-1:0]    PAT0    = 'h0000_0000,
    parameter logic [DATA_W-1:0]    PAT1    = 'hAAAA_AAAA,
    parameter logic [DATA_W-1:0]    PAT2    = 'h1234_5678
) (
    input  logic [CPT_RND_W-1:0] round,
    input  logic [FIELD_W-1:0]   tune_hi,
    input  logic [FIELD_W-1:0]   tune_mid,
    input  logic [FIELD_W-1:0]   tune_lo,
    input  logic [DATA_W-1:0]    stamp,
    output logic [DATA_W-1:0]    pattern
);

    logic [DATA_W-1:0] tune_word;

    always_comb begin
        // Shift-and-OR packing of the three tuning fields
        tune_word = (DATA_W'(tune_hi)  << (2 * FIELD_W))
                  | (DATA_W'(tune_mid) << FIELD_W)
                  |  DATA_W'(tune_lo);
        case (round)
            CPT_RND_W'(0): pattern = PAT0;
            CPT_RND_W'(1): pattern = PAT1;
            CPT_RND_W'(2): pattern = PAT2;
            CPT_RND_W'(3): pattern = tune_word;
            CPT_RND_W'(4): pattern = stamp;
            default:       pattern = '0;
        endcase
    end

endmodule

// File: rtl/cpt_sequencer.sv
module cpt_sequencer
    import cpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    test_addr,
    input  logic [DATA_W-1:0]    pat_in,
    output logic [CPT_RND_W-1:0] load_round,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 pass
);

    localparam logic [CPT_RND_W-1:0] LAST_RND = CPT_RND_W'(CPT_ROUNDS - 1);
    localparam logic [ADDR_W-1:0]    WORD_OFS = ADDR_W'(4);

    typedef struct packed {
        cpt_state_e           st;
        logic [CPT_RND_W-1:0] rnd;
        logic [DATA_W-1:0]    pat;
        logic [ADDR_W-1:0]    addr;
        logic                 done;
        logic                 pass;
    } seq_t;

    seq_t seq_d, seq_q;
    logic match_lo, match_hi;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load_round = '0;
        match_lo   = (mem_rdata == seq_q.pat);
        match_hi   = (mem_rdata == ~seq_q.pat);
        case (seq_q.st)
            ST_IDLE: begin
                load_round = '0;
                if (start) begin
                    seq_d.st   = ST_WR_LO;
                    seq_d.rnd  = '0;
                    seq_d.pat  = pat_in;
                    seq_d.addr = test_addr;
                    seq_d.pass = 1'b0;
                end
            end
            ST_WR_LO: begin
                if (mem_ack) seq_d.st = ST_WR_HI;
            end
            ST_WR_HI: begin
                if (mem_ack) seq_d.st = ST_RD_LO;
            end
            ST_RD_LO: begin
                if (mem_ack) begin
                    if (match_lo) begin
                        seq_d.st = ST_RD_HI;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.pass = 1'b0;
                    end
                end
            end
            ST_RD_HI: begin
                load_round = seq_q.rnd + CPT_RND_W'(1);
                if (mem_ack) begin
                    if (!match_hi) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.pass = 1'b0;
                    end else if (seq_q.rnd == LAST_RND) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.pass = 1'b1;
                    end else begin
                        seq_d.st  = ST_WR_LO;
                        seq_d.rnd = seq_q.rnd + CPT_RND_W'(1);
                        seq_d.pat = pat_in;
                    end
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.rnd  <= '0;
            seq_q.pat  <= '0;
            seq_q.addr <= '0;
            seq_q.done <= 1'b0;
            seq_q.pass <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        mem_req   = (seq_q.st != ST_IDLE);
        mem_we    = (seq_q.st == ST_WR_LO) || (seq_q.st == ST_WR_HI);
        mem_addr  = ((seq_q.st == ST_WR_HI) || (seq_q.st == ST_RD_HI))
                  ? seq_q.addr + WORD_OFS : seq_q.addr;
        mem_wdata = (seq_q.st == ST_WR_HI) ? ~seq_q.pat : seq_q.pat;
    end

    assign done = seq_q.done;
    assign pass = seq_q.pass;

    // R10: a waiting request keeps its fields
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    // R3: a write directly after an acknowledged write carries the inverse, one word up
    a_r3_complement_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we && mem_ack))
        |-> (mem_wdata == ~$past(mem_wdata)) && (mem_addr == $past(mem_addr) + WORD_OFS));

    // R9: the end-of-run pulse lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6 / R7: no request accompanies the end-of-run pulse
    a_r6_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R8: start during a pending request changes nothing at the port
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && start) |=> (mem_req && $stable(mem_addr)));

    // R9: pass holds while idle without a new start
    a_r9_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_req && !start) && !mem_req && !done) |-> $stable(pass));

endmodule

// File: rtl/cpair_mem_tester.sv
module cpair_mem_tester
    import cpt_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          DATA_W    = 32,
    parameter int unsigned          SEED_W    = 8,
    parameter int unsigned          FIELD_W   = 8,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 'hA000_0000,
    parameter logic [DATA_W-1:0]    PAT0      = 'h0000_0000,
    parameter logic [DATA_W-1:0]    PAT1      = 'hAAAA_AAAA,
    parameter logic [DATA_W-1:0]    PAT2      = 'h1234_5678
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SEED_W-1:0]  seed,
    input  logic [FIELD_W-1:0] tune_hi,
    input  logic [FIELD_W-1:0] tune_mid,
    input  logic [FIELD_W-1:0] tune_lo,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               done,
    output logic               pass
);

    localparam logic [ADDR_W-1:0] OFS_MIN = ADDR_W'(((1 << SEED_W) - 1) * 4);
    localparam logic [ADDR_W-1:0] OFS_MAX = ADDR_W'(((1 << SEED_W) - 1) * 8 + 4);

    logic [ADDR_W-1:0]    test_addr;
    logic [DATA_W-1:0]    stamp;
    logic [DATA_W-1:0]    pat_next;
    logic [CPT_RND_W-1:0] load_round;

    cpt_addr_gen #(
        .ADDR_W    (ADDR_W),
        .SEED_W    (SEED_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr (
        .seed      (seed),
        .test_addr (test_addr)
    );

    cpt_cycle_ctr #(
        .CNT_W (DATA_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (stamp)
    );

    cpt_pattern_sel #(
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W),
        .PAT0    (PAT0),
        .PAT1    (PAT1),
        .PAT2    (PAT2)
    ) u_pat (
        .round    (load_round),
        .tune_hi  (tune_hi),
        .tune_mid (tune_mid),
        .tune_lo  (tune_lo),
        .stamp    (stamp),
        .pattern  (pat_next)
    );

    cpt_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .test_addr  (test_addr),
        .pat_in     (pat_next),
        .load_round (load_round),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .pass       (pass)
    );

    // R2: every access falls inside the seed-reachable word-aligned window
    a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - BASE_ADDR) >= OFS_MIN)
                 && ((mem_addr - BASE_ADDR) <= OFS_MAX)
                 && (mem_addr[1:0] == 2'b00));

    // R1: nothing is requested in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!mem_req && !done && !pass));

endmodule

// File: tb/cpair_mem_tester_test.sv
module cpair_mem_tester_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'hA000_0000;
    localparam int          NVEC       = 7;
    // {seed[8], hi[8], mid[8], lo[8], latency[2], fail_read[4] (0 = none), mid_start[1]}
    localparam logic [38:0] VEC [NVEC] = '{
        {8'h00, 24'h010203, 2'd0, 4'd0,  1'b0},
        {8'hFF, 24'hA55AC3, 2'd1, 4'd0,  1'b0},
        {8'h37, 24'h000000, 2'd3, 4'd0,  1'b1},
        {8'h80, 24'h112233, 2'd0, 4'd1,  1'b0},
        {8'h01, 24'hFFFFFF, 2'd2, 4'd10, 1'b0},
        {8'h5C, 24'h123456, 2'd1, 4'd7,  1'b1},
        {8'h9A, 24'h0F0E0D, 2'd0, 4'd9,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  seed = '0, tune_hi = '0, tune_mid = '0, tune_lo = '0;
    logic        mem_req, mem_we, done, pass;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0, n_fails = 0;

    // memory model state (written only by the model)
    logic [31:0] mem [512];
    int          lg_n = 0, rd_n = 0, req_n = 0, wcnt = 0;
    logic        prev_req = 1'b0;
    logic [31:0] lg_addr [64];
    logic        lg_we   [64];
    logic [31:0] lg_data [64];
    logic [31:0] exp5 = '0;
    int          tb_cnt = 0;
    // model controls (written only by the test sequence)
    int          lat_r = 0, fail_r = 0, base_rd = 0, base_req = 0;

    cpair_mem_tester uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .tune_hi(tune_hi), .tune_mid(tune_mid), .tune_lo(tune_lo),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .pass(pass)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Edges since reset release (R5)
    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= 0;
        else        tb_cnt <= tb_cnt + 1;
    end

    // Single-outstanding memory with programmable wait and read corruption
    always @(negedge clk) begin
        logic was_ack;
        int   idx;
        was_ack = mem_ack;
        mem_ack = 1'b0;
        if (!rst_n) begin
            wcnt     = 0;
            prev_req = 1'b0;
        end else begin
            if (mem_req && (was_ack || !prev_req)) begin
                req_n = req_n + 1;
                wcnt  = 0;
                if (req_n - base_req == 17) exp5 = tb_cnt - 1;
            end
            if (mem_req) begin
                if (wcnt >= lat_r) begin
                    idx = int'((mem_addr - BASE) >> 2) % 512;
                    mem_ack = 1'b1;
                    lg_addr[lg_n % 64] = mem_addr;
                    lg_we[lg_n % 64]   = mem_we;
                    lg_data[lg_n % 64] = mem_wdata;
                    lg_n = lg_n + 1;
                    if (mem_we) begin
                        mem[idx] = mem_wdata;
                    end else begin
                        rd_n = rd_n + 1;
                        mem_rdata = mem[idx];
                        if (rd_n - base_rd == fail_r) mem_rdata = mem_rdata ^ 32'h1;
                    end
                end else begin
                    wcnt = wcnt + 1;
                end
            end
            prev_req = mem_req;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat_of(input int r, input logic [23:0] tune, input logic [31:0] e5);
        case (r)
            0: return 32'h0000_0000;
            1: return 32'hAAAA_AAAA;
            2: return 32'h1234_5678;
            3: return {8'h00, tune};
            default: return e5;
        endcase
    endfunction

    task automatic run_one(input logic [38:0] v);
        logic [7:0]  s;
        logic [23:0] tn;
        logic [31:0] a, p, ea, ed;
        int fr, nt, exp_nt, base_log, cyc, r, k, idx;
        bit exp_pass, got_done, ewe;
        s  = v[38:31];
        tn = v[30:7];
        fr = int'(v[4:1]);
        @(negedge clk);
        lat_r = int'(v[6:5]); fail_r = fr;
        base_rd = rd_n; base_req = req_n; base_log = lg_n;
        seed = s; tune_hi = tn[23:16]; tune_mid = tn[15:8]; tune_lo = tn[7:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 0;
        for (cyc = 0; cyc < 2000 && !got_done; cyc++) begin
            if (v[0] && cyc == 4) begin start = 1'b1; seed = ~s; end
            else if (v[0] && cyc == 5) begin start = 1'b0; seed = s; end
            if (done) got_done = 1;
            else @(negedge clk);
        end
        start = 1'b0;
        chk(got_done, "R6/R7 done never seen", {31'b0, got_done}, 32'd1);
        exp_pass = (fr == 0);
        exp_nt   = exp_pass ? 20 : ((fr - 1) / 2) * 4 + 3 + ((fr - 1) % 2);
        chk(pass == exp_pass, exp_pass ? "R6 pass result" : "R7 fail result",
            {31'b0, pass}, {31'b0, exp_pass});
        nt = lg_n - base_log;
        chk(nt == exp_nt, "R6/R7/R8 request count", nt, exp_nt);
        a = BASE + ((32'(s) + 32'd255) << 2);
        for (int i = 0; i < nt && i < exp_nt; i++) begin
            r = i / 4; k = i % 4;
            idx = (base_log + i) % 64;
            p   = pat_of(r, tn, exp5);
            ea  = a + ((k % 2) ? 32'd4 : 32'd0);
            ewe = (k < 2);
            ed  = (k == 0) ? p : ~p;
            chk(lg_addr[idx] == ea, "R2/R3/R8 address", lg_addr[idx], ea);
            chk(lg_we[idx] == ewe, "R3 access kind", {31'b0, lg_we[idx]}, {31'b0, ewe});
            if (ewe) begin
                if (r == 4) chk(lg_data[idx] == ed, "R5 counter pattern", lg_data[idx], ed);
                else        chk(lg_data[idx] == ed, "R4 pattern", lg_data[idx], ed);
            end
        end
        @(negedge clk);
        chk(!done, "R9 done width", {31'b0, done}, 32'd0);
        chk(pass == exp_pass, "R9 pass held", {31'b0, pass}, {31'b0, exp_pass});
        chk(!mem_req, "R6/R7 no request after end", {31'b0, mem_req}, 32'd0);
        repeat (4) @(negedge clk);
        chk(pass == exp_pass && !mem_req, "R9 pass held while idle", {31'b0, pass}, {31'b0, exp_pass});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!done && !pass && !mem_req, "R1 state in reset", {29'b0, done, pass, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !pass && !mem_req, "R1 state after reset", {29'b0, done, pass, mem_req}, 32'd0);

        for (int n = 0; n < NVEC; n++) run_one(VEC[n]);

        // Reset during a run clears the port and the result (R1)
        @(negedge clk);
        seed = 8'h10; lat_r = 1; fail_r = 0; base_rd = rd_n; base_req = req_n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(mem_req, "R3 run in progress", {31'b0, mem_req}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_req && !done && !pass, "R1 reset mid-run", {29'b0, done, pass, mem_req}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !pass, "R1 idle after mid-run reset", {29'b0, done, pass, mem_req}, 32'd0);

        // A further passing run after reset, counter restarted (R5)
        run_one({8'hC4, 24'h00FF00, 2'd2, 4'd0, 1'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule